// File: doc/BRIEF.md
# Dual-Port Byte Memory with Same-Address Arbitration

This block is a true dual-port memory with two fully independent access ports, called left and right. Each port carries its own address, write data, read data with a read-valid flag, a write strobe, an output enable, a select line that must be held high for ordinary memory traffic, and a pair of chip enables of opposite polarity. Every port input is sampled on one shared clock. A read returns its data one clock after it is sampled. Both ports may read the same word in the same cycle.

When the strap input `master_sel` is high, the block arbitrates between the ports. If both ports are selected on the same address in the same cycle and at least one of them writes, the left port wins. The right port's busy flag is pulled low for that cycle, and the right port's write is dropped. When the strap is low, the block is a slave in a cascade. Each port then takes a busy input from an external master. A low busy input blocks that port's write but still lets the port read. The busy outputs are always driven and are never tri-stated. Memory depth is set by the address-width parameter. The scaled-down default keeps elaboration small, and the width is raised to 16 for a 64K-word part.

Top module: `dpram_arb`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0, its `ce1` is 1 and its `sem_n` is 1. Any other combination performs no write, and the port's `dout_vld` is 0 one clock later.
- R2: A selected port with `we_n` = 0 stores `din` at `addr` on the clock edge, whatever the value of `oe_n`. Its `dout_vld` is 0 one clock later.
- R3: A selected port with `we_n` = 1 and `oe_n` = 0 shows the stored word on `dout` with `dout_vld` = 1 one clock later. With `oe_n` = 1, `dout_vld` is 0 one clock later.
- R4: A read sampled in the same cycle as a write to the same address by the other port returns the word held before that write.
- R5: Both ports reading the same address in the same cycle both receive the stored word.
- R6: With `master_sel` = 1, if both ports are selected on the same address and at least one writes, `r_busy_out_n` is 0 and `l_busy_out_n` is 1 in that same cycle (no clock delay). The right port's write is suppressed, and the left port's write takes effect.
- R7: With `master_sel` = 1 and no such collision, both busy outputs are 1.
- R8: With `master_sel` = 0, both busy outputs are held at 1. A port whose busy input is 0 has its write suppressed, but its read still completes.
- R9: With `master_sel` = 0 and no busy input asserted, if both ports write the same address in one cycle, the left port's data is stored.
- R10: While `rst_n` is low at a clock edge, both `dout_vld` outputs are 0 after that edge.
- R11: Whenever a port's `dout_vld` is 0, its `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_sel | input | 1 | 1 = arbitrating master, 0 = cascaded slave |
| l_ce0_n | input | 1 | Left enable, active low |
| l_ce1 | input | 1 | Left enable, active high |
| l_we_n | input | 1 | Left write strobe, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left memory-space select, must be 1 |
| l_addr | input | AW | Left address |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left read data |
| l_dout_vld | output | 1 | Left read data valid (stands in for a bus drive enable) |
| l_busy_in_n | input | 1 | Left busy input used in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_ce0_n | input | 1 | Right enable, active low |
| r_ce1 | input | 1 | Right enable, active high |
| r_we_n | input | 1 | Right write strobe, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right memory-space select, must be 1 |
| r_addr | input | AW | Right address |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right read data |
| r_dout_vld | output | 1 | Right read data valid |
| r_busy_in_n | input | 1 | Right busy input used in slave mode, active low |
| r_busy_out_n | output | 1 | Right busy flag, active low |

## Verification
The busy outputs depend only on the current inputs, so the bench checks them in the same cycle, after it drives inputs on the falling edge and before the next rising edge. Read data and its valid flag come from registers and are due one rising edge after the access is sampled. The bench therefore checks them at the following falling edge. A write becomes visible to a read sampled on the next edge or any later edge. For that reason, every check for a stored or suppressed write is a separate read issued after the write cycle has ended.

// File: rtl/dpram_pkg.sv
// Shared types for the dual-port memory.
// Assumes: nothing beyond IEEE 1800-2017.
package dpram_pkg;

    // Decoded access request of one port for the current cycle.
    typedef struct packed {
        logic sel;  // port selected for memory traffic
        logic wr;   // write requested
        logic rd;   // read with output enabled
    } acc_t;

endpackage

// File: rtl/dpram_port_dec.sv
// Turns the raw control pins of one port into a decoded request.
// Assumes: all pins are already synchronous to the common clock.
module dpram_port_dec
    import dpram_pkg::*;
(
    input  logic ce0_n,
    input  logic ce1,
    input  logic we_n,
    input  logic oe_n,
    input  logic sem_n,
    output acc_t acc
);

    // Select needs both enables true and the memory-space select high.
    always_comb begin
        acc.sel = !ce0_n && ce1 && sem_n;
        acc.wr  = acc.sel && !we_n;
        acc.rd  = acc.sel && we_n && !oe_n;
    end

endmodule

// File: rtl/dpram_arbiter.sv
// Same-address collision arbiter and write gating.
// Master mode: left wins ties and the right port gets busy for that cycle.
// Slave mode: the external busy inputs gate writes, and busy outputs stay high.
// Assumes: busy outputs are combinational from the sampled inputs.
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          master_sel,
    input  acc_t          l_acc,
    input  acc_t          r_acc,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    input  logic          l_busy_in_n,
    input  logic          r_busy_in_n,
    output logic          l_busy_out_n,
    output logic          r_busy_out_n,
    output logic          l_wr_en,
    output logic          r_wr_en
);

    logic clash;

    // Collision: both selected on one address with at least one write.
    always_comb begin
        clash = l_acc.sel && r_acc.sel && (l_addr == r_addr) && (l_acc.wr || r_acc.wr);
    end

    // Busy generation and write gating for the strapped mode.
    always_comb begin
        if (master_sel) begin
            l_busy_out_n = 1'b1;
            r_busy_out_n = !clash;
            l_wr_en      = l_acc.wr;
            r_wr_en      = r_acc.wr && !clash;
        end else begin
            l_busy_out_n = 1'b1;
            r_busy_out_n = 1'b1;
            l_wr_en      = l_acc.wr && l_busy_in_n;
            r_wr_en      = r_acc.wr && r_busy_in_n;
        end
    end

endmodule

// File: rtl/dpram_core.sv
// Storage array with two write and two read ports; reads return the old word.
// Assumes: when both write one address in a cycle, the left data lands.
module dpram_core #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_din,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_din,
    output logic [DW-1:0] l_q,
    output logic [DW-1:0] r_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read-first access; the right write is ordered before the left write so left wins.
    always_ff @(posedge clk) begin
        l_q <= mem[l_addr];
        r_q <= mem[r_addr];
        if (r_we) mem[r_addr] <= r_din;
        if (l_we) mem[l_addr] <= l_din;
    end

endmodule

// File: rtl/dpram_rd_stage.sv
// Output stage of one port: read-valid register and zero masking of data.
// Assumes: raw_q is the registered array word for the request sampled on the same edge.
module dpram_rd_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [DW-1:0] raw_q,
    output logic [DW-1:0] dout,
    output logic          dout_vld
);

    // Capture whether a read was sampled this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_vld <= 1'b0;
        else        dout_vld <= rd_req;
    end

    // Present data only while valid, zeros otherwise.
    always_comb begin
        dout = dout_vld ? raw_q : '0;
    end

endmodule

// File: rtl/dpram_arb.sv
// Top: dual-port memory with chip-enable decode, collision arbitration
// and a master/slave busy strap.
// Assumes: all port inputs are synchronous to clk; reset is synchronous active low.
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_sel,
    input  logic          l_ce0_n,
    input  logic          l_ce1,
    input  logic          l_we_n,
    input  logic          l_oe_n,
    input  logic          l_sem_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_din,
    output logic [DW-1:0] l_dout,
    output logic          l_dout_vld,
    input  logic          l_busy_in_n,
    output logic          l_busy_out_n,
    input  logic          r_ce0_n,
    input  logic          r_ce1,
    input  logic          r_we_n,
    input  logic          r_oe_n,
    input  logic          r_sem_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_din,
    output logic [DW-1:0] r_dout,
    output logic          r_dout_vld,
    input  logic          r_busy_in_n,
    output logic          r_busy_out_n
);

    localparam int NP = 2;

    acc_t          acc   [NP];
    logic          rd    [NP];
    logic [DW-1:0] raw_q [NP];
    logic [DW-1:0] dout  [NP];
    logic          vld   [NP];
    logic          l_wr_en;
    logic          r_wr_en;

    dpram_port_dec u_dec_l (
        .ce0_n (l_ce0_n), .ce1 (l_ce1), .we_n (l_we_n),
        .oe_n  (l_oe_n),  .sem_n (l_sem_n), .acc (acc[0])
    );

    dpram_port_dec u_dec_r (
        .ce0_n (r_ce0_n), .ce1 (r_ce1), .we_n (r_we_n),
        .oe_n  (r_oe_n),  .sem_n (r_sem_n), .acc (acc[1])
    );

    dpram_arbiter #(.AW(AW)) u_arb (
        .master_sel   (master_sel),
        .l_acc        (acc[0]),
        .r_acc        (acc[1]),
        .l_addr       (l_addr),
        .r_addr       (r_addr),
        .l_busy_in_n  (l_busy_in_n),
        .r_busy_in_n  (r_busy_in_n),
        .l_busy_out_n (l_busy_out_n),
        .r_busy_out_n (r_busy_out_n),
        .l_wr_en      (l_wr_en),
        .r_wr_en      (r_wr_en)
    );

    dpram_core #(.AW(AW), .DW(DW)) u_core (
        .clk    (clk),
        .l_we   (l_wr_en),
        .l_addr (l_addr),
        .l_din  (l_din),
        .r_we   (r_wr_en),
        .r_addr (r_addr),
        .r_din  (r_din),
        .l_q    (raw_q[0]),
        .r_q    (raw_q[1])
    );

    // One output stage per port.
    for (genvar p = 0; p < NP; p++) begin : g_out
        assign rd[p] = acc[p].rd;
        dpram_rd_stage #(.DW(DW)) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_req   (rd[p]),
            .raw_q    (raw_q[p]),
            .dout     (dout[p]),
            .dout_vld (vld[p])
        );
    end

    assign l_dout     = dout[0];
    assign l_dout_vld = vld[0];
    assign r_dout     = dout[1];
    assign r_dout_vld = vld[1];

endmodule

// File: rtl/dpram_arb_chk.sv
// Port-level property checker, bound to every dpram_arb instance.
// Assumes: sees only the top-level ports.
module dpram_arb_chk #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_sel,
    input logic          l_ce0_n,
    input logic          l_ce1,
    input logic          l_we_n,
    input logic          l_oe_n,
    input logic          l_sem_n,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_dout,
    input logic          l_dout_vld,
    input logic          l_busy_out_n,
    input logic          r_ce0_n,
    input logic          r_ce1,
    input logic          r_we_n,
    input logic          r_oe_n,
    input logic          r_sem_n,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_dout,
    input logic          r_dout_vld,
    input logic          r_busy_out_n
);

    logic l_on, r_on, hit;

    // Port selection and collision as seen from the pins.
    always_comb begin
        l_on = !l_ce0_n && l_ce1 && l_sem_n;
        r_on = !r_ce0_n && r_ce1 && r_sem_n;
        hit  = l_on && r_on && (l_addr == r_addr) && (!l_we_n || !r_we_n);
    end

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !l_on |=> !l_dout_vld);

    assert_write_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_on && !r_we_n) |=> !r_dout_vld);

    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_on && l_we_n && !l_oe_n) |=> l_dout_vld);

    assert_clash_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && hit) |-> (!r_busy_out_n && l_busy_out_n));

    assert_calm_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !hit) |-> (l_busy_out_n && r_busy_out_n));

    assert_slave_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (l_busy_out_n && r_busy_out_n));

    assert_zero_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_dout_vld |-> (l_dout == '0)) and (!r_dout_vld |-> (r_dout == '0)));

endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_dpram_arb.sv
// Directed bench: inputs change on the falling edge, results are checked there too.
module tb_dpram_arb;

    localparam int AW = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_sel = 1'b1;
    logic l_ce0_n, l_ce1, l_we_n, l_oe_n, l_sem_n, l_busy_in_n;
    logic r_ce0_n, r_ce1, r_we_n, r_oe_n, r_sem_n, r_busy_in_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_din, r_din, l_dout, r_dout;
    logic l_dout_vld, r_dout_vld, l_busy_out_n, r_busy_out_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dpram_arb #(.AW(AW), .DW(DW)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drv_l(input logic c0n, c1, wn, on, sn, input int a, input int d);
        l_ce0_n = c0n; l_ce1 = c1; l_we_n = wn; l_oe_n = on; l_sem_n = sn;
        l_addr = AW'(a); l_din = DW'(d);
    endtask

    task automatic drv_r(input logic c0n, c1, wn, on, sn, input int a, input int d);
        r_ce0_n = c0n; r_ce1 = c1; r_we_n = wn; r_oe_n = on; r_sem_n = sn;
        r_addr = AW'(a); r_din = DW'(d);
    endtask

    task automatic idle();
        drv_l(1, 0, 1, 1, 1, 0, 0);
        drv_r(1, 0, 1, 1, 1, 0, 0);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read one address from the left port; returns the data and valid seen one clock later.
    task automatic rd_l(input int a, output int d, output int v);
        drv_l(0, 1, 1, 0, 1, a, 0);
        cyc();
        d = int'(l_dout); v = int'(l_dout_vld);
        idle();
    endtask

    task automatic wr_l(input int a, input int d);
        drv_l(0, 1, 0, 1, 1, a, d);
        cyc();
        idle();
    endtask

    task automatic t_reset();
        chk("R10 vld l", int'(l_dout_vld), 0);
        chk("R10 vld r", int'(r_dout_vld), 0);
        chk("R11 dout l", int'(l_dout), 0);
    endtask

    task automatic t_write_read();
        int d, v;
        drv_l(0, 1, 0, 0, 1, 5, 'hA5);      // write with oe_n low: oe ignored
        cyc();
        chk("R2 no vld on write", int'(l_dout_vld), 0);
        chk("R11 zero on write", int'(l_dout), 0);
        idle();
        drv_r(0, 1, 1, 0, 1, 5, 0);
        cyc();
        chk("R3 read data", int'(r_dout), 'hA5);
        chk("R3 read vld", int'(r_dout_vld), 1);
        drv_r(0, 1, 1, 1, 1, 5, 0);         // oe_n high
        cyc();
        chk("R3 oe high vld", int'(r_dout_vld), 0);
        idle();
        rd_l(5, d, v);
        chk("R2 left read back", d, 'hA5);
    endtask

    task automatic t_deselect();
        int d, v;
        drv_l(1, 1, 0, 0, 1, 5, 'h01); cyc();
        chk("R1 ce0 high vld", int'(l_dout_vld), 0);
        drv_l(0, 0, 0, 0, 1, 5, 'h02); cyc();
        chk("R1 ce1 low vld", int'(l_dout_vld), 0);
        drv_l(0, 1, 0, 0, 0, 5, 'h03); cyc();
        chk("R1 sem low vld", int'(l_dout_vld), 0);
        drv_l(0, 1, 1, 0, 0, 5, 0); cyc();
        chk("R1 sem low read vld", int'(l_dout_vld), 0);
        idle();
        rd_l(5, d, v);
        chk("R1 no write landed", d, 'hA5);
    endtask

    task automatic t_dual_read();
        drv_l(0, 1, 1, 0, 1, 5, 0);
        drv_r(0, 1, 1, 0, 1, 5, 0);
        #1;
        chk("R7 busy l idle", int'(l_busy_out_n), 1);
        chk("R7 busy r dual read", int'(r_busy_out_n), 1);
        cyc();
        chk("R5 left data", int'(l_dout), 'hA5);
        chk("R5 right data", int'(r_dout), 'hA5);
        chk("R5 both vld", int'(l_dout_vld & r_dout_vld), 1);
        idle();
    endtask

    task automatic t_collision();
        int d, v;
        drv_l(0, 1, 0, 1, 1, 9, 'h11);
        drv_r(0, 1, 0, 1, 1, 9, 'h22);
        #1;
        chk("R6 busy r low", int'(r_busy_out_n), 0);
        chk("R6 busy l high", int'(l_busy_out_n), 1);
        cyc();
        idle();
        rd_l(9, d, v);
        chk("R6 left wins", d, 'h11);
        drv_l(0, 1, 0, 1, 1, 9, 'h33);
        drv_r(0, 1, 1, 0, 1, 9, 0);
        #1;
        chk("R6 busy r on read", int'(r_busy_out_n), 0);
        cyc();
        chk("R4 old data", int'(r_dout), 'h11);
        chk("R4 vld despite busy", int'(r_dout_vld), 1);
        drv_l(0, 1, 1, 0, 1, 9, 0);
        drv_r(0, 1, 0, 1, 1, 9, 'h44);
        #1;
        chk("R6 busy r on write", int'(r_busy_out_n), 0);
        cyc();
        chk("R4 left sees pre-write", int'(l_dout), 'h33);
        idle();
        rd_l(9, d, v);
        chk("R6 right write dropped", d, 'h33);
        drv_l(0, 1, 0, 1, 1, 12, 'h5A);
        drv_r(0, 1, 0, 1, 1, 13, 'hC3);
        #1;
        chk("R7 distinct addr busy", int'(r_busy_out_n), 1);
        cyc();
        idle();
        rd_l(13, d, v);
        chk("R7 right write kept", d, 'hC3);
    endtask

    task automatic t_slave();
        int d, v;
        master_sel = 1'b0;
        wr_l(20, 'h66);
        r_busy_in_n = 1'b0;
        drv_r(0, 1, 0, 1, 1, 20, 'h55);
        #1;
        chk("R8 slave busy l", int'(l_busy_out_n), 1);
        chk("R8 slave busy r", int'(r_busy_out_n), 1);
        cyc();
        drv_r(0, 1, 1, 0, 1, 20, 0);
        cyc();
        chk("R8 blocked write", int'(r_dout), 'h66);
        chk("R8 read while busy", int'(r_dout_vld), 1);
        idle();
        r_busy_in_n = 1'b1;
        l_busy_in_n = 1'b0;
        wr_l(21, 'h99);
        l_busy_in_n = 1'b1;
        rd_l(21, d, v);
        chk("R8 left blocked", d, 'h00);
        drv_l(0, 1, 0, 1, 1, 30, 'h77);
        drv_r(0, 1, 0, 1, 1, 30, 'h88);
        #1;
        chk("R8 no busy out on tie", int'(r_busy_out_n), 1);
        cyc();
        idle();
        rd_l(30, d, v);
        chk("R9 left data kept", d, 'h77);
        master_sel = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        l_busy_in_n = 1'b1;
        r_busy_in_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wr_l(21, 'h00);
        t_write_read();
        t_deselect();
        t_dual_read();
        t_collision();
        t_slave();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule